// File: doc/BRIEF.md
# Element-Granular Burst Read Adapter

This block connects a compute kernel to an AXI4 memory-mapped read channel. The kernel issues read commands, each naming a starting element index and an element count relative to a fixed base address. The commands wait in a small bounded queue. A burst generator converts each command into one or more incrementing AR bursts, never longer than a configured beat limit and never crossing a 4 KB address page. Returned R beats land in a data FIFO, and the kernel takes elements out one at a time through a valid/ready pop port, in the same order as its commands.

A queue slot is given back only once the kernel has popped every element of that command, not when the bus accepts the address. Issuing more commands than the queue holds, without popping in between, therefore stalls the kernel at the command port. The generator issues a burst only when the data FIFO is sure to hold all of its beats, so the R channel is always ready. It also caps the number of bursts in flight. Two sticky flags report a pop attempted with no command pending and an R response other than OKAY.

Top module: `mbr_read_adapter`

## Requirements
- R1: A burst address equals `base_addr + offset * (DATA_W/8)`, `arsize` equals log2 of the element size in bytes (2 for 32-bit elements), and `arburst` is always 2'b01 (incrementing).
- R2: A command longer than `MAX_BURST` elements is split into consecutive bursts of `MAX_BURST` beats followed by the remainder; each burst has `arlen` = beats - 1 and starts where the previous one ended.
- R3: No burst crosses a 4 KB address boundary; a command reaching a boundary is cut there and continues with a new burst at the boundary address.
- R4: `cmd_ready` is high while the command queue holds fewer than `CMD_DEPTH` entries and low when it is full; a command is accepted on a cycle with `cmd_valid` and `cmd_ready` both high.
- R5: A queue slot is freed only on the clock edge where the kernel pops the last element of the oldest command; popping earlier elements leaves `cmd_ready` low in a full queue.
- R6: `el_valid` is high only when a returned element is waiting, and elements come out in command order, each command's elements in rising address order.
- R7: No more than `MAX_OUTSTANDING` AR bursts are in flight (address accepted, last beat not yet returned) at any time.
- R8: A burst is issued only when the data FIFO can hold all beats not yet popped, so `rready` is always high and the FIFO never overflows; with no pops, a 40-element command issues only one 16-beat burst.
- R9: A pop attempted (`el_ready` high) while no command is pending sets the sticky flag `pop_err`.
- R10: An R beat with `rresp` other than 2'b00 sets the sticky flag `resp_err`; that beat's data is still delivered.
- R11: After reset `cmd_ready` is 1, `arvalid` and `el_valid` are 0, `rready` is 1 and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_addr | input | ADDR_W | Byte address of element 0, aligned to the element size |
| cmd_valid | input | 1 | Kernel offers a read command |
| cmd_off | input | OFF_W | Starting element index of the command |
| cmd_len | input | LEN_W | Number of elements, at least 1 |
| cmd_ready | output | 1 | Command queue has a free slot |
| el_ready | input | 1 | Kernel wants one element |
| el_valid | output | 1 | An element is available |
| el_data | output | DATA_W | Element value |
| pop_err | output | 1 | Sticky: pop attempted with no command pending |
| resp_err | output | 1 | Sticky: a non-OKAY read response was seen |
| arvalid | output | 1 | AR channel valid |
| arready | input | 1 | AR channel ready |
| araddr | output | ADDR_W | Burst start byte address |
| arlen | output | 8 | Beats minus one |
| arsize | output | 3 | log2 of bytes per beat |
| arburst | output | 2 | Burst type, always incrementing |
| rvalid | input | 1 | R channel valid |
| rready | output | 1 | R channel ready, held high |
| rdata | input | DATA_W | Read data beat |
| rresp | input | 2 | Read response code |
| rlast | input | 1 | Last beat of a burst |

## Verification
The assertions assume a well-behaved memory side: R beats belong to accepted bursts, arrive in issue order, carry exactly `arlen`+1 beats with `rlast` on the final one, and `base_addr` stays constant and element-aligned. They also assume the kernel gives non-zero lengths and keeps `cmd_valid` and its fields steady until accepted. The bench's memory model queues each accepted address and answers it beat by beat only after the handshake. The kernel tasks push non-zero commands and hold them until accepted, and they pop exactly the total length pushed, except in the one scenario that deliberately pops from an empty queue.

// File: rtl/mbr_pkg.sv
// Package: shared constants for the burst read adapter.
// Assumes nothing beyond the AXI4 encodings it names.
package mbr_pkg;
    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] RESP_OKAY  = 2'b00;
    localparam int unsigned PAGE_BYTES = 4096;
endpackage

// File: rtl/mbr_cmd_queue.sv
// Command queue: holds read commands from push until all of their
// elements have been popped. A separate issue pointer hands commands to
// the burst generator in order; the retire pointer advances when the
// last element of the oldest command is popped.
// Assumes DEPTH is a power of two >= 2 and every command length >= 1.
module mbr_cmd_queue #(
    parameter int OFF_W = 20,
    parameter int LEN_W = 12,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [OFF_W-1:0] push_off,
    input  logic [LEN_W-1:0] push_len,
    output logic             push_ready,
    output logic             iss_valid,
    output logic [OFF_W-1:0] iss_off,
    output logic [LEN_W-1:0] iss_len,
    input  logic             iss_take,
    input  logic             pop_fire,
    output logic             q_empty
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    logic [OFF_W-1:0] off_mem [DEPTH];
    logic [LEN_W-1:0] len_mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, iss_ptr, rt_ptr;
    logic [PTR_W-1:0] used;
    logic [LEN_W-1:0] popped;
    logic [LEN_W-1:0] head_len;
    logic             head_done;
    logic             push_fire;

    // Occupancy and handshake decode.
    always_comb begin
        used       = wr_ptr - rt_ptr;
        push_ready = (used != PTR_W'(DEPTH));
        q_empty    = (used == '0);
        push_fire  = push_valid && push_ready;
        iss_valid  = (iss_ptr != wr_ptr);
        iss_off    = off_mem[iss_ptr[IDX_W-1:0]];
        iss_len    = len_mem[iss_ptr[IDX_W-1:0]];
        head_len   = len_mem[rt_ptr[IDX_W-1:0]];
        head_done  = (popped + LEN_W'(1)) == head_len;
    end

    // Store accepted commands.
    always_ff @(posedge clk) begin
        if (push_fire) begin
            off_mem[wr_ptr[IDX_W-1:0]] <= push_off;
            len_mem[wr_ptr[IDX_W-1:0]] <= push_len;
        end
    end

    // Pointer and per-command pop counter maintenance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            iss_ptr <= '0;
            rt_ptr  <= '0;
            popped  <= '0;
        end else begin
            if (push_fire) wr_ptr <= wr_ptr + PTR_W'(1);
            if (iss_take && iss_valid) iss_ptr <= iss_ptr + PTR_W'(1);
            if (pop_fire) begin
                if (head_done) begin
                    rt_ptr <= rt_ptr + PTR_W'(1);
                    popped <= '0;
                end else begin
                    popped <= popped + LEN_W'(1);
                end
            end
        end
    end

    // R5: a slot is only freed by a pop.
    assert_retire_on_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_fire |=> $stable(rt_ptr));
    // R4: a full queue accepts nothing.
    assert_no_push_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_ready && !pop_fire) |=> $stable(wr_ptr) && !push_ready);
    // R6: elements are only popped while a command is pending.
    assert_pop_has_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_fire |-> !q_empty);
endmodule

// File: rtl/mbr_data_fifo.sv
// Data FIFO: buffers returned read beats until the kernel pops them.
// Assumes DEPTH is a power of two >= 2; the producer never pushes when full.
module mbr_data_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             full;

    // Status decode.
    always_comb begin
        empty = (wp == rp);
        full  = (wp - rp) == PTR_W'(DEPTH);
        dout  = mem[rp[IDX_W-1:0]];
    end

    // Data storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wp[IDX_W-1:0]] <= din;
    end

    // Pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= wp + PTR_W'(1);
            if (pop && !empty) rp <= rp + PTR_W'(1);
        end
    end

    // R8: space reservation upstream means no push ever meets a full FIFO.
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
endmodule

// File: rtl/mbr_burst_gen.sv
// Burst generator: takes one command at a time from the queue, turns it
// into incrementing AR bursts limited by MAX_BURST and by 4 KB pages,
// and holds back a burst while MAX_OUT bursts are in flight or while the
// data FIFO could not take all of its beats.
// Assumes base_addr is element-aligned, ADDR_W >= 12, MAX_BURST <= 256
// and MAX_BURST <= DATA_DEPTH.
module mbr_burst_gen
    import mbr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 20,
    parameter int LEN_W      = 12,
    parameter int DATA_W     = 32,
    parameter int MAX_BURST  = 16,
    parameter int MAX_OUT    = 2,
    parameter int DATA_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              iss_valid,
    input  logic [OFF_W-1:0]  iss_off,
    input  logic [LEN_W-1:0]  iss_len,
    output logic              iss_take,
    input  logic              pop_fire,
    input  logic              r_last_fire,
    output logic              arvalid,
    input  logic              arready,
    output logic [ADDR_W-1:0] araddr,
    output logic [7:0]        arlen,
    output logic [2:0]        arsize,
    output logic [1:0]        arburst
);
    localparam int EB    = DATA_W / 8;
    localparam int SZ    = $clog2(EB);
    localparam int BT_W  = $clog2(MAX_BURST + 1);
    localparam int OUT_W = $clog2(MAX_OUT + 1);
    localparam int CR_W  = $clog2(DATA_DEPTH + 1);

    logic              busy;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  rem;
    logic              arvalid_q;
    logic [ADDR_W-1:0] araddr_q;
    logic [BT_W-1:0]   ar_beats;
    logic [OUT_W-1:0]  out_cnt;
    logic [CR_W-1:0]   credit;
    logic [12:0]       to_page;
    logic [31:0]       beats_c;
    logic              can_issue;
    logic              ar_fire;

    // Size of the next burst and whether it may be issued.
    always_comb begin
        to_page = (13'h1000 - {1'b0, cur_addr[11:0]}) >> SZ;
        beats_c = 32'(rem);
        if (beats_c > 32'(MAX_BURST)) beats_c = 32'(MAX_BURST);
        if (beats_c > 32'(to_page))   beats_c = 32'(to_page);
        can_issue = busy && !arvalid_q && (rem != '0)
                 && (32'(out_cnt) < 32'(MAX_OUT))
                 && (32'(credit) + beats_c <= 32'(DATA_DEPTH));
        iss_take  = !busy && iss_valid;
        ar_fire   = arvalid_q && arready;
    end

    // Command walk: load a command, then step through its bursts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cur_addr  <= '0;
            rem       <= '0;
            arvalid_q <= 1'b0;
            araddr_q  <= '0;
            ar_beats  <= '0;
        end else begin
            if (iss_take) begin
                busy     <= 1'b1;
                cur_addr <= base_addr + (ADDR_W'(iss_off) << SZ);
                rem      <= iss_len;
            end else if (can_issue) begin
                arvalid_q <= 1'b1;
                araddr_q  <= cur_addr;
                ar_beats  <= BT_W'(beats_c);
                cur_addr  <= cur_addr + (ADDR_W'(beats_c) << SZ);
                rem       <= rem - LEN_W'(beats_c);
            end else if (ar_fire) begin
                arvalid_q <= 1'b0;
                if (rem == '0) busy <= 1'b0;
            end
        end
    end

    // In-flight burst count and reserved FIFO space.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_cnt <= '0;
            credit  <= '0;
        end else begin
            case ({ar_fire, r_last_fire})
                2'b10:   out_cnt <= out_cnt + OUT_W'(1);
                2'b01:   out_cnt <= out_cnt - OUT_W'(1);
                default: out_cnt <= out_cnt;
            endcase
            credit <= credit + (ar_fire ? CR_W'(ar_beats) : CR_W'(0))
                             - (pop_fire ? CR_W'(1) : CR_W'(0));
        end
    end

    // AR channel outputs.
    always_comb begin
        arvalid = arvalid_q;
        araddr  = araddr_q;
        arlen   = 8'(ar_beats) - 8'd1;
        arsize  = 3'(SZ);
        arburst = BURST_INCR;
    end

    // R7: a burst is accepted only below the in-flight limit.
    assert_out_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ar_fire |-> 32'(out_cnt) < 32'(MAX_OUT));
    // R3: no burst runs past a 4 KB page.
    assert_no_page_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid |-> (32'(araddr[11:0]) + ((32'(arlen) + 32'd1) << SZ)) <= 32'(PAGE_BYTES));
    // R2: burst length bound and stability while waiting.
    assert_len_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid |-> 32'(arlen) < 32'(MAX_BURST));
    assert_ar_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && !arready) |=> arvalid && $stable(araddr) && $stable(arlen));
endmodule

// File: rtl/mbr_read_adapter.sv
// Top: element-granular burst read adapter. Ties together the command
// queue, the burst generator and the data FIFO, keeps R ready high and
// raises sticky error flags.
// Assumes DATA_W is a power of two from 8 to 1024, CMD_DEPTH and
// DATA_DEPTH are powers of two, MAX_BURST <= min(256, DATA_DEPTH), and
// R beats come back in order with rlast on each burst's final beat.
module mbr_read_adapter
    import mbr_pkg::*;
#(
    parameter int ADDR_W          = 32,
    parameter int DATA_W          = 32,
    parameter int OFF_W           = 20,
    parameter int LEN_W           = 12,
    parameter int CMD_DEPTH       = 4,
    parameter int DATA_DEPTH      = 16,
    parameter int MAX_BURST       = 16,
    parameter int MAX_OUTSTANDING = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              cmd_valid,
    input  logic [OFF_W-1:0]  cmd_off,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_ready,
    input  logic              el_ready,
    output logic              el_valid,
    output logic [DATA_W-1:0] el_data,
    output logic              pop_err,
    output logic              resp_err,
    output logic              arvalid,
    input  logic              arready,
    output logic [ADDR_W-1:0] araddr,
    output logic [7:0]        arlen,
    output logic [2:0]        arsize,
    output logic [1:0]        arburst,
    input  logic              rvalid,
    output logic              rready,
    input  logic [DATA_W-1:0] rdata,
    input  logic [1:0]        rresp,
    input  logic              rlast
);
    logic             iss_valid, iss_take, q_empty;
    logic [OFF_W-1:0] iss_off;
    logic [LEN_W-1:0] iss_len;
    logic             pop_fire, r_fire, r_last_fire, fifo_empty;

    // Handshake decode.
    always_comb begin
        rready      = 1'b1;
        r_fire      = rvalid;
        r_last_fire = rvalid && rlast;
        el_valid    = !fifo_empty;
        pop_fire    = el_ready && el_valid;
    end

    mbr_cmd_queue #(.OFF_W(OFF_W), .LEN_W(LEN_W), .DEPTH(CMD_DEPTH)) u_cmdq (
        .clk(clk), .rst_n(rst_n),
        .push_valid(cmd_valid), .push_off(cmd_off), .push_len(cmd_len),
        .push_ready(cmd_ready),
        .iss_valid(iss_valid), .iss_off(iss_off), .iss_len(iss_len),
        .iss_take(iss_take), .pop_fire(pop_fire), .q_empty(q_empty)
    );

    mbr_burst_gen #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LEN_W(LEN_W), .DATA_W(DATA_W),
        .MAX_BURST(MAX_BURST), .MAX_OUT(MAX_OUTSTANDING), .DATA_DEPTH(DATA_DEPTH)
    ) u_bgen (
        .clk(clk), .rst_n(rst_n), .base_addr(base_addr),
        .iss_valid(iss_valid), .iss_off(iss_off), .iss_len(iss_len),
        .iss_take(iss_take), .pop_fire(pop_fire), .r_last_fire(r_last_fire),
        .arvalid(arvalid), .arready(arready), .araddr(araddr),
        .arlen(arlen), .arsize(arsize), .arburst(arburst)
    );

    mbr_data_fifo #(.W(DATA_W), .DEPTH(DATA_DEPTH)) u_dfifo (
        .clk(clk), .rst_n(rst_n),
        .push(r_fire), .din(rdata),
        .pop(pop_fire), .dout(el_data), .empty(fifo_empty)
    );

    // Sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_err  <= 1'b0;
            resp_err <= 1'b0;
        end else begin
            if (el_ready && q_empty) pop_err <= 1'b1;
            if (rvalid && (rresp != RESP_OKAY)) resp_err <= 1'b1;
        end
    end

    // R10: the response error flag never clears outside reset.
    assert_resp_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |=> resp_err);
    // R9: a pop with nothing pending is flagged on the next cycle.
    assert_pop_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (el_ready && q_empty) |=> pop_err);
    // R6: available data always belongs to a pending command.
    assert_valid_has_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        el_valid |-> !q_empty);
    // R1: fixed burst attributes on every request.
    assert_attr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid |-> (arburst == BURST_INCR) && (arsize == 3'($clog2(DATA_W / 8))));
endmodule

// File: tb/sim_mbr_read_adapter.sv
module sim_mbr_read_adapter;
    localparam int ADDR_W = 32, DATA_W = 32, OFF_W = 20, LEN_W = 12;
    localparam logic [31:0] BASE = 32'h1000_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [OFF_W-1:0]  cmd_off = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic              cmd_ready;
    logic              el_ready = 1'b0;
    logic              el_valid;
    logic [DATA_W-1:0] el_data;
    logic              pop_err, resp_err;
    logic              arvalid, arready;
    logic [ADDR_W-1:0] araddr;
    logic [7:0]        arlen;
    logic [2:0]        arsize;
    logic [1:0]        arburst;
    logic              rvalid, rready, rlast;
    logic [DATA_W-1:0] rdata;
    logic [1:0]        rresp;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mbr_read_adapter u0 (
        .clk(clk), .rst_n(rst_n), .base_addr(BASE),
        .cmd_valid(cmd_valid), .cmd_off(cmd_off), .cmd_len(cmd_len), .cmd_ready(cmd_ready),
        .el_ready(el_ready), .el_valid(el_valid), .el_data(el_data),
        .pop_err(pop_err), .resp_err(resp_err),
        .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
        .arsize(arsize), .arburst(arburst),
        .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp), .rlast(rlast)
    );

    // Memory model state, updated at falling edges only.
    logic [31:0] q_addr [256];
    int          q_len  [256];
    logic [31:0] log_addr [256];
    int          log_len  [256];
    int q_head = 0, q_tail = 0, beat = 0;
    int ar_total = 0, done_bursts = 0, bad_attr = 0, max_out = 0;
    bit r_hold = 0, inject = 0;
    logic rv_b = 0, rl_b = 0;
    logic [31:0] rd_b = '0;
    logic [1:0]  rr_b = '0;
    assign arready = 1'b1;
    assign rvalid = rv_b;
    assign rlast  = rl_b;
    assign rdata  = rd_b;
    assign rresp  = rr_b;

    function automatic logic [31:0] memf(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            q_head = 0; q_tail = 0; beat = 0; ar_total = 0; done_bursts = 0;
            rv_b = 0; rl_b = 0; max_out = 0; bad_attr = 0;
        end else begin
            if (rv_b) begin
                if (rl_b) begin done_bursts++; q_head++; beat = 0; end
                else beat++;
                rv_b = 0; rl_b = 0;
            end
            if (!r_hold && q_head != q_tail) begin
                rd_b = memf(q_addr[q_head] + 32'(beat * 4));
                rl_b = (beat == q_len[q_head]);
                rr_b = inject ? 2'b10 : 2'b00;
                inject = 0;
                rv_b = 1;
            end
            if (arvalid && arready) begin
                q_addr[q_tail] = araddr; q_len[q_tail] = int'(arlen); q_tail++;
                log_addr[ar_total] = araddr; log_len[ar_total] = int'(arlen);
                if (arsize != 3'd2 || arburst != 2'b01) bad_attr++;
                ar_total++;
            end
            if (ar_total - done_bursts > max_out) max_out = ar_total - done_bursts;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; cmd_valid = 0; el_ready = 0; r_hold = 0; inject = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic push_cmd(input int off, input int len);
        @(negedge clk); cmd_valid = 1; cmd_off = OFF_W'(off); cmd_len = LEN_W'(len);
        while (!cmd_ready) @(negedge clk);
        @(negedge clk); cmd_valid = 0;
    endtask

    task automatic pop_one(input int off, input string req);
        logic [31:0] got;
        pop_en_wait: begin
            el_ready = 1;
            while (!el_valid) @(negedge clk);
            got = el_data;
            @(negedge clk); el_ready = 0;
        end
        check(got == memf(BASE + 32'(off * 4)), req, 64'(got), 64'(memf(BASE + 32'(off * 4))));
    endtask

    // R11: reset values at the ports.
    task automatic t_reset();
        do_reset();
        check(cmd_ready == 1 && arvalid == 0 && el_valid == 0 && rready == 1,
              "R11 idle ports", {cmd_ready, arvalid, el_valid, rready}, 4'b1001);
        check(pop_err == 0 && resp_err == 0, "R11 flags clear", {pop_err, resp_err}, 0);
    endtask

    // R1, R6: one short command.
    task automatic t_single();
        int a0 = ar_total;
        push_cmd(16, 4);
        for (int i = 0; i < 4; i++) pop_one(16 + i, "R6 single data");
        check(ar_total - a0 == 1, "R1 one burst", ar_total - a0, 1);
        check(log_addr[a0] == BASE + 32'h40, "R1 address", log_addr[a0], BASE + 32'h40);
        check(log_len[a0] == 3, "R1 arlen", log_len[a0], 3);
        check(bad_attr == 0, "R1 size/burst", bad_attr, 0);
    endtask

    // R2: a 40-element command splits 16/16/8.
    task automatic t_split();
        int a0 = ar_total;
        push_cmd(0, 40);
        for (int i = 0; i < 40; i++) pop_one(i, "R2 split data");
        check(ar_total - a0 == 3, "R2 burst count", ar_total - a0, 3);
        check(log_addr[a0+1] == BASE + 32'h40 && log_len[a0+1] == 15, "R2 second burst",
              log_addr[a0+1], BASE + 32'h40);
        check(log_addr[a0+2] == BASE + 32'h80 && log_len[a0+2] == 7, "R2 tail burst",
              {log_addr[a0+2], 8'(log_len[a0+2])}, {BASE + 32'h80, 8'd7});
    endtask

    // R3: page boundary cut at byte 0x1000.
    task automatic t_page();
        int a0 = ar_total;
        push_cmd(32'h3FC, 10);
        for (int i = 0; i < 10; i++) pop_one(32'h3FC + i, "R3 page data");
        check(ar_total - a0 == 2, "R3 burst count", ar_total - a0, 2);
        check(log_addr[a0] == BASE + 32'hFF0 && log_len[a0] == 3, "R3 first burst",
              {log_addr[a0], 8'(log_len[a0])}, {BASE + 32'hFF0, 8'd3});
        check(log_addr[a0+1] == BASE + 32'h1000 && log_len[a0+1] == 5, "R3 second burst",
              {log_addr[a0+1], 8'(log_len[a0+1])}, {BASE + 32'h1000, 8'd5});
    endtask

    // R4, R5, R6: fill the queue, retire by popping.
    task automatic t_full();
        for (int c = 0; c < 4; c++) push_cmd(32'h300 + c * 8, 2);
        repeat (10) @(negedge clk);
        check(cmd_ready == 0, "R4 full queue blocks", cmd_ready, 0);
        pop_one(32'h300, "R6 order");
        check(cmd_ready == 0, "R5 slot held mid-command", cmd_ready, 0);
        pop_one(32'h301, "R6 order");
        check(cmd_ready == 1, "R5 slot freed at last pop", cmd_ready, 1);
        for (int c = 1; c < 4; c++) begin
            pop_one(32'h300 + c * 8, "R6 order across commands");
            pop_one(32'h301 + c * 8, "R6 order across commands");
        end
    endtask

    // R7: in-flight burst limit with responses held.
    task automatic t_outstanding();
        int a0 = ar_total;
        @(negedge clk); r_hold = 1;
        for (int c = 0; c < 4; c++) push_cmd(32'h500 + c * 16, 2);
        repeat (20) @(negedge clk);
        check(ar_total - a0 == 2, "R7 issue stops at limit", ar_total - a0, 2);
        r_hold = 0;
        for (int c = 0; c < 4; c++) begin
            pop_one(32'h500 + c * 16, "R7 data");
            pop_one(32'h501 + c * 16, "R7 data");
        end
        check(max_out <= 2, "R7 max in flight", max_out, 2);
    endtask

    // R8: FIFO space reservation without pops.
    task automatic t_credit();
        int a0 = ar_total;
        push_cmd(32'h100, 40);
        repeat (60) @(negedge clk);
        check(ar_total - a0 == 1, "R8 one burst until pops", ar_total - a0, 1);
        check(rready == 1, "R8 rready high", rready, 1);
        for (int i = 0; i < 40; i++) pop_one(32'h100 + i, "R8 data");
        check(ar_total - a0 == 3, "R8 all bursts issued", ar_total - a0, 3);
    endtask

    // R10: non-OKAY response flagged, data kept.
    task automatic t_resp();
        @(negedge clk); inject = 1;
        push_cmd(32'h200, 1);
        pop_one(32'h200, "R10 data delivered");
        check(resp_err == 1, "R10 resp_err set", resp_err, 1);
        repeat (3) @(negedge clk);
        check(resp_err == 1, "R10 resp_err sticky", resp_err, 1);
    endtask

    // R9: pop with nothing pending.
    task automatic t_pop_err();
        check(pop_err == 0, "R9 flag clear before", pop_err, 0);
        @(negedge clk); el_ready = 1;
        @(negedge clk); el_ready = 0;
        check(pop_err == 1, "R9 pop_err set", pop_err, 1);
        check(el_valid == 0, "R9 no element produced", el_valid, 0);
        repeat (3) @(negedge clk);
        check(pop_err == 1, "R9 pop_err sticky", pop_err, 1);
    endtask

    initial begin
        t_reset();
        t_single();
        t_split();
        t_page();
        t_full();
        t_outstanding();
        t_credit();
        t_pop_err();
        t_resp();
        t_reset();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule